// File: doc/BRIEF.md
# Small Read Cache with Selectable Associativity

This block is a read-only cache for a tiny byte-addressed space of 32 bytes. It always holds four lines of two bytes each. The parameter `WAYS` sets how those lines are arranged. A value of 1 gives a direct-mapped cache, 2 gives a two-way set-associative cache, and 4 gives a fully associative cache. The processor presents an address with a valid/ready handshake. One response later comes back with the addressed byte and a flag that tells whether the access hit.

A miss raises a line-fill request to the backing memory for the even-aligned two-byte block and holds it until memory answers. The returned block is written into a way of the selected set. An invalid way is used first; when every way is valid, the least recently used way is replaced. The requested byte is then returned with the hit flag low. Two saturating counters record the number of hits and misses since reset.

Top module: `rdcache`

## Requirements
- R1: Address bit 0 picks the byte within a line. `rsp_data` is always the byte stored at `req_addr`. `fill_addr` is the request address with bit 0 forced to 0. The byte at the even address arrives on `fill_data[7:0]` and the byte at the odd address on `fill_data[15:8]`.
- R2: With `WAYS`=1, address bits [2:1] select one of four lines and bits [4:3] are the tag. The load trace 1,5,1,4,0,12,5,12,5,12,5 yields M M H H H M M M M M M, which is 3 hits and 8 misses.
- R3: With `WAYS`=4 there is no index and bits [4:1] are the tag. The same trace yields M M H H H M H H H H H, which is 8 hits and 3 misses.
- R4: With `WAYS`=2, bit 1 selects one of two sets and bits [4:2] are the tag. The same trace yields M M H H H M M H H H H, which is 7 hits and 4 misses.
- R5: When a miss finds every way of its set valid, the least recently used way is replaced. Both hits and fills count as uses.
- R6: Reset invalidates every line. A miss fills an invalid way of its set before it evicts any valid way.
- R7: A miss raises `fill_req` in the cycle after acceptance. `fill_req` and `fill_addr` stay steady and `req_ready` stays low until a cycle with `fill_valid`. The response, with `rsp_hit`=0, comes in the cycle after that.
- R8: A hit raises `rsp_valid` with `rsp_hit`=1 in the cycle after acceptance and issues no fill.
- R9: `hit_count` and `miss_count` clear on reset, increase by one for each hit or miss, and hold at their all-ones value.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. After reset, `req_ready` is high and `rsp_valid` and `fill_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 5 | Byte address of the load |
| req_ready | output | 1 | Cache can accept a request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | 8 | Loaded byte |
| rsp_hit | output | 1 | 1 if the load hit, 0 if it missed |
| fill_req | output | 1 | Line fill request to memory |
| fill_addr | output | 5 | Even-aligned address of the block to fill |
| fill_valid | input | 1 | Memory returns the block this cycle |
| fill_data | input | 16 | Block data, even byte in the low half |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The bench drives the fixed load trace into all three associativities at once and checks each outcome against the stated hit and miss patterns. A design that used the wrong address bits for index or tag would break at least one of those patterns. Directed sequences cover the following cases:
- A set is filled, one way is touched, and then a new block must evict the stale way. Choosing the victim by way number instead of by recency would miss on the block that was just touched.
- Two blocks of the same set are loaded right after reset. Overwriting a valid way while another way is still free would turn the second access into a miss.

Constrained random traffic is then compared with a timestamp-based reference model. The run is long enough to push the hit counter past its limit, where a counter without saturation would wrap to a small value. A final reset followed by a repeated load shows that stale valid bits are gone.

// File: rtl/rdcache.sv
module rdcache #(
  parameter int WAYS  = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [4:0]       req_addr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [7:0]       rsp_data,
  output logic             rsp_hit,
  output logic             fill_req,
  output logic [4:0]       fill_addr,
  input  logic             fill_valid,
  input  logic [15:0]      fill_data,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int LINES = 4;
  localparam int SETS  = LINES / WAYS;
  localparam int IXB   = $clog2(SETS);
  localparam int TAG_W = 4 - IXB;

  logic             busy_q;
  logic [4:0]       pend_q;
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [15:0]      blk_q [LINES];
  logic [1:0]       age_q [LINES];

  function automatic logic [1:0] line_of(logic [1:0] s, int w);
    return 2'(int'(s) * WAYS + w);
  endfunction

  logic [4:0]       cur_addr;
  logic [3:0]       cur_blk;
  logic [1:0]       cur_set;
  logic [TAG_W-1:0] cur_tag;
  assign cur_addr = busy_q ? pend_q : req_addr;
  assign cur_blk  = cur_addr[4:1];
  assign cur_set  = 2'(cur_blk & 4'(SETS - 1));
  assign cur_tag  = TAG_W'(cur_blk >> IXB);

  logic       hit;
  logic [1:0] hit_way;
  logic [1:0] vic_way;
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[line_of(cur_set, w)] && tag_q[line_of(cur_set, w)] == cur_tag) begin
        hit     = 1'b1;
        hit_way = 2'(w);
      end
      if (age_q[line_of(cur_set, w)] == 2'(WAYS - 1)) vic_way = 2'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[line_of(cur_set, w)]) vic_way = 2'(w);
  end

  logic accept, do_fill, touch;
  logic [1:0] use_way, fill_line;
  logic [1:0] use_age;
  assign accept    = req_valid && !busy_q;
  assign do_fill   = busy_q && fill_valid;
  assign touch     = (accept && hit) || do_fill;
  assign use_way   = busy_q ? vic_way : hit_way;
  assign use_age   = age_q[line_of(cur_set, int'(use_way))];
  assign fill_line = line_of(cur_set, int'(vic_way));

  assign req_ready = !busy_q;
  assign fill_req  = busy_q;
  assign fill_addr = {pend_q[4:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_data   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept && hit) begin
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_data  <= req_addr[0] ? blk_q[line_of(cur_set, int'(hit_way))][15:8]
                                 : blk_q[line_of(cur_set, int'(hit_way))][7:0];
        if (!(&hit_count)) hit_count <= hit_count + 1'b1;
      end else if (accept) begin
        busy_q <= 1'b1;
        pend_q <= req_addr;
        if (!(&miss_count)) miss_count <= miss_count + 1'b1;
      end else if (do_fill) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_data  <= pend_q[0] ? fill_data[15:8] : fill_data[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int l = 0; l < LINES; l++) begin
        tag_q[l] <= '0;
        blk_q[l] <= '0;
      end
    end else if (do_fill) begin
      vld_q[fill_line] <= 1'b1;
      tag_q[fill_line] <= cur_tag;
      blk_q[fill_line] <= fill_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LINES; l++) age_q[l] <= 2'(l % WAYS);
    end else if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (2'(w) == use_way)
          age_q[line_of(cur_set, w)] <= '0;
        else if (age_q[line_of(cur_set, w)] < use_age)
          age_q[line_of(cur_set, w)] <= age_q[line_of(cur_set, w)] + 2'd1;
      end
    end
  end
endmodule

module rdcache_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             fill_req,
  input logic             fill_valid,
  input logic [4:0]       fill_addr,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R10
  accept_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || fill_req));
  // R7
  fill_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && !req_ready && $stable(fill_addr)));
  // R7
  fill_then_miss_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (rsp_valid && !rsp_hit && req_ready));
  // R1
  fill_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !fill_addr[0]);
  // R9
  hit_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_count >= $past(hit_count));
  // R9
  miss_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_count >= $past(miss_count));
  // R9
  hit_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (hit_count != $past(hit_count) || (&hit_count)));
endmodule

bind rdcache rdcache_chk #(.CNT_W(CNT_W)) u_rdcache_chk (.*);

// File: tb/test_rdcache.sv
`timescale 1ns/1ps
module test_rdcache;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] mem_byte(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  for (genvar g = 0; g < 3; g++) begin : gen_cfg
    localparam int W = (g == 0) ? 1 : (g == 1) ? 2 : 4;
    localparam int S = 4 / W;

    logic        rst_n, req_valid, req_ready, rsp_valid, rsp_hit, fill_req, fill_valid;
    logic [4:0]  req_addr, fill_addr;
    logic [7:0]  rsp_data;
    logic [15:0] fill_data;
    logic [7:0]  hit_count, miss_count;
    int n_chk = 0;
    int n_fail = 0;
    bit fin = 0;

    rdcache #(.WAYS(W), .CNT_W(8)) i_rdcache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_hit(rsp_hit), .fill_req(fill_req), .fill_addr(fill_addr),
      .fill_valid(fill_valid), .fill_data(fill_data),
      .hit_count(hit_count), .miss_count(miss_count));

    int m_blk [4];
    bit m_v [4];
    int m_st [4];
    int stamp, e_hit, e_miss;

    task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
        n_fail++;
        $display("FAIL ways=%0d %s actual=%0d expected=%0d", W, req, act, exp);
      end
    endtask

    task automatic model_reset();
      for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_blk[i] = 0; m_st[i] = 0; end
      stamp = 0; e_hit = 0; e_miss = 0;
    endtask

    task automatic model(int a, output bit h);
      int s, b, v;
      s = (a >> 1) % S;
      b = a >> 1;
      h = 0;
      stamp++;
      for (int w = 0; w < W; w++)
        if (m_v[s*W+w] && m_blk[s*W+w] == b) begin h = 1; m_st[s*W+w] = stamp; end
      if (h) e_hit++;
      else begin
        e_miss++;
        v = -1;
        for (int w = 0; w < W; w++) if (!m_v[s*W+w] && v < 0) v = w;
        if (v < 0) begin
          v = 0;
          for (int w = 1; w < W; w++) if (m_st[s*W+w] < m_st[s*W+v]) v = w;
        end
        m_v[s*W+v] = 1; m_blk[s*W+v] = b; m_st[s*W+v] = stamp;
      end
    endtask

    task automatic access(int a, int exp_hit, string req);
      bit h;
      model(a, h);
      if (exp_hit < 0) exp_hit = int'(h);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 5'(a);
      @(negedge clk);
      req_valid = 1'b0;
      if (!rsp_valid) begin
        check("R7 fill_req on miss", int'(fill_req), 1);
        check("R7 req_ready low during fill", int'(req_ready), 0);
        check("R1 fill_addr aligned", int'(fill_addr), a & 30);
        @(negedge clk);
        check("R7 still waiting for fill", int'(rsp_valid), 0);
        check("R7 fill_addr steady", int'(fill_addr), a & 30);
        fill_valid = 1'b1;
        fill_data  = {mem_byte(a | 1), mem_byte(a & 30)};
        @(negedge clk);
        fill_valid = 1'b0;
      end else begin
        check("R8 no fill on hit", int'(fill_req), 0);
      end
      check("R10 response present", int'(rsp_valid), 1);
      check(req, int'(rsp_hit), exp_hit);
      check("R1 data byte", int'(rsp_data), int'(mem_byte(a)));
    endtask

    task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; fill_valid = 1'b0; fill_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(negedge clk);
      check("R10 ready after reset", int'(req_ready), 1);
      check("R10 no response after reset", int'(rsp_valid), 0);
      check("R10 no fill after reset", int'(fill_req), 0);
      check("R9 hit_count cleared", int'(hit_count), 0);
      check("R9 miss_count cleared", int'(miss_count), 0);
    endtask

    initial begin
      int trace [11] = '{1, 5, 1, 4, 0, 12, 5, 12, 5, 12, 5};
      string pat, tr_req;
      int eh, a;
      pat    = (W == 1) ? "MMHHHMMMMMM" : (W == 2) ? "MMHHHMMHHHH" : "MMHHHMHHHHH";
      tr_req = (W == 1) ? "R2 trace" : (W == 2) ? "R4 trace" : "R3 trace";
      eh     = (W == 1) ? 3 : (W == 2) ? 7 : 8;
      do_reset();
      for (int i = 0; i < 11; i++) access(trace[i], int'(pat[i] == "H"), tr_req);
      check({tr_req, " hits"}, int'(hit_count), eh);
      check({tr_req, " misses"}, int'(miss_count), 11 - eh);

      do_reset();
      access(0, 0, "R6 first fill");
      access(4, 0, "R6 second fill");
      access(0, (W == 1) ? 1 : 1, "R6 free way used");
      access(4, 1, "R6 free way used");

      do_reset();
      access(0, 0, "R5 warm");
      access(2, 0, "R5 warm");
      access(4, 0, "R5 warm");
      access(6, 0, "R5 warm");
      access(0, -1, "R5 touch");
      access(8, -1, "R5 evict lru");
      access(0, -1, "R5 recent kept");
      access(2, -1, "R5 lru gone");

      do_reset();
      void'($urandom(1234 + g));
      for (int i = 0; i < 600; i++) begin
        a = (i < 350) ? int'($urandom % 8) : int'($urandom % 32);
        access(a, -1, "R5 random vs model");
      end
      check("R9 hit_count saturates", int'(hit_count), (e_hit > 255) ? 255 : e_hit);
      check("R9 miss_count value", int'(miss_count), (e_miss > 255) ? 255 : e_miss);

      do_reset();
      access(1, 0, "R6 reset invalidates");
      access(1, 1, "R8 hit after fill");
      fin = 1;
    end
  end

  initial begin
    int tc, tf;
    while (!(gen_cfg[0].fin && gen_cfg[1].fin && gen_cfg[2].fin) && cyc < 150000)
      @(posedge clk);
    tc = gen_cfg[0].n_chk + gen_cfg[1].n_chk + gen_cfg[2].n_chk;
    tf = gen_cfg[0].n_fail + gen_cfg[1].n_fail + gen_cfg[2].n_fail;
    if (!(gen_cfg[0].fin && gen_cfg[1].fin && gen_cfg[2].fin)) begin
      tc++;
      tf++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", tc, tf);
    $finish;
  end
endmodule